// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block drives IEEE 802.3 Clause 22 management frames on an MDC/MDIO pin pair under the control of a 32-bit register bus. Software loads a control word that holds the target PHY port and register number. If the control word carries the read command, the frame starts at once. Otherwise the frame starts when the 16-bit payload is written to the data register. While a frame is on the wire, the configuration register shows a busy flag. After a read, the data register holds the value the PHY returned. If the PHY did not pull the line low during the turnaround, a read-error flag is set instead.

MDC comes from a parameterised divider of the system clock. The master changes MDIO just after MDC falls and samples it as MDC rises. During a read, the master stops driving the line for the PHY's part of the frame. A static strap selects the byte order of the register bus, and the block swaps bytes on writes and on read-back. The Clause 45 select bit is only kept and read back. All frames use Clause 22 encoding.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads as zero, `mdio_oe` is low and `mdio_o` is high.
- R2: A write frame is 64 bits, most significant first: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10`, then 16 data bits. `mdio_oe` is high for all 64 bits.
- R3: A read frame starts when the control register (offset 0x34) is written with bit 15 set. Its first 47 bits are 32 ones, `01`, opcode `10`, PHY address, register address and a `1`. `mdio_oe` is low from bit index 47 (the second turnaround bit) through bit 63. The 16 bits sampled on MDC rising edges for bit indices 48..63 appear in bits 15:0 of the data register (offset 0x38), most significant first.
- R4: Configuration register bit 31 (offset 0x30) reads 1 from the cycle after a frame starts until the frame completes, and 0 once it has completed.
- R5: Configuration bit 1 becomes 1 when a read completes with MDIO sampled high at bit index 47. It returns to 0 when the next frame starts.
- R6: While busy, writes to the control and data registers have no effect: they do not change the frame in flight, the stored fields or the data register. This holds even when such a write falls in the cycle the frame completes.
- R7: A data-register write made while the stored control word has bit 15 set stores the value and starts no frame.
- R8: With `big_endian` high, the bytes of write data and read data are reversed: bits 31:24 are exchanged with 7:0, and bits 23:16 with 15:8.
- R9: Configuration bit 6 (Clause 45 select) and the 16-bit address register (offset 0x3C) keep what is written and read it back, and starting no frame.
- R10: MDC has a period of 2×`MDC_HALF` system clocks. `mdio_o` changes only on the system clock edge at which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte-order select for the register bus |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Management data sampled from the pin |

## Verification
Two events can fall in the same cycle: the completion of a read, which loads the data register from the shifter, and a software write to the data register. The bench provokes this by writing the data register on every cycle of a read frame. It stops only after the last MDC rising edge, so one of those writes lands on the completing edge itself. The data register must then read back the PHY's value, not the written one. Busy and the error flag must show the frame as finished.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PHY_BITS   = 5;
   localparam int REGA_BITS  = 5;
   localparam int DATA_BITS  = 16;
   localparam int PRE_BITS   = 32;
   localparam int FRAME_LEN  = PRE_BITS + 4 + PHY_BITS + REGA_BITS + 2 + DATA_BITS;
   localparam int TA2_IDX    = PRE_BITS + 4 + PHY_BITS + REGA_BITS + 1;
   localparam int DATA0_IDX  = TA2_IDX + 1;
   localparam logic [1:0] SOF      = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] TA_WRITE = 2'b10;
   localparam logic [1:0] TA_READ  = 2'b11;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int HALF_PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

   logic [CW-1:0] cnt;
   logic          tick;

   generate
      if (HALF_PERIOD < 1) begin : g_bad_half
         $error("HALF_PERIOD must be at least 1");
      end
      if (HALF_PERIOD == 1) begin : g_tick_every
         assign tick = 1'b1;
      end else begin : g_tick_count
         assign tick = (cnt == CW'(HALF_PERIOD - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign rise_stb = tick & ~mdc;
   assign fall_stb = tick &  mdc;

   p_half_period_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> (mdc && !fall_stb));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fall_stb,
   input  logic                 rise_stb,
   input  logic                 start,
   input  logic                 start_rd,
   input  logic [PHY_BITS-1:0]  start_phy,
   input  logic [REGA_BITS-1:0] start_reg,
   input  logic [DATA_BITS-1:0] start_data,
   input  logic                 mdio_i,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   output logic                 busy,
   output logic                 done,
   output logic                 done_rd,
   output logic [DATA_BITS-1:0] rd_word,
   output logic                 ta_fail
);
   localparam int CNT_W = $clog2(FRAME_LEN + 1);
   localparam int IDX_W = $clog2(FRAME_LEN);

   generate
      if (DATA_BITS < 2) begin : g_bad_data
         $error("DATA_BITS must be at least 2");
      end
   endgenerate

   logic [FRAME_LEN-1:0] frame_q;
   logic [CNT_W-1:0]     next_q;
   logic [IDX_W-1:0]     cur_q;
   logic                 active_q, driven_q, is_rd_q, ta_q;
   logic [DATA_BITS-1:0] sh_q;
   logic [FRAME_LEN-1:0] frame_init;

   always_comb begin
      frame_init = {{PRE_BITS{1'b1}}, SOF,
                    start_rd ? OP_READ : OP_WRITE,
                    start_phy, start_reg,
                    start_rd ? TA_READ : TA_WRITE,
                    start_rd ? {DATA_BITS{1'b1}} : start_data};
   end

   assign done    = active_q & driven_q & rise_stb & (cur_q == IDX_W'(FRAME_LEN - 1));
   assign done_rd = is_rd_q;
   assign rd_word = {sh_q[DATA_BITS-2:0], mdio_i};
   assign ta_fail = is_rd_q & ta_q;
   assign busy    = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q  <= '0;
         next_q   <= '0;
         cur_q    <= '0;
         active_q <= 1'b0;
         driven_q <= 1'b0;
         is_rd_q  <= 1'b0;
         ta_q     <= 1'b0;
         sh_q     <= '0;
         mdio_o   <= 1'b1;
         mdio_oe  <= 1'b0;
      end else if (!active_q) begin
         if (start) begin
            frame_q  <= frame_init;
            next_q   <= '0;
            active_q <= 1'b1;
            driven_q <= 1'b0;
            is_rd_q  <= start_rd;
            ta_q     <= 1'b0;
         end
      end else begin
         if (fall_stb && (next_q < CNT_W'(FRAME_LEN))) begin
            mdio_o   <= frame_q[FRAME_LEN-1];
            mdio_oe  <= !(is_rd_q && (next_q >= CNT_W'(TA2_IDX)));
            frame_q  <= {frame_q[FRAME_LEN-2:0], 1'b1};
            cur_q    <= next_q[IDX_W-1:0];
            next_q   <= next_q + 1'b1;
            driven_q <= 1'b1;
         end
         if (rise_stb && driven_q) begin
            if (cur_q == IDX_W'(TA2_IDX)) ta_q <= mdio_i;
            if (cur_q >= IDX_W'(DATA0_IDX)) sh_q <= {sh_q[DATA_BITS-2:0], mdio_i};
            if (done) begin
               active_q <= 1'b0;
               mdio_oe  <= 1'b0;
            end
         end
      end
   end

   p_done_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   p_read_release_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_rd_q && driven_q && (cur_q >= IDX_W'(TA2_IDX))) |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
   import mdio_pkg::*;
#(
   parameter int              AW      = 8,
   parameter logic [AW-1:0]   OFS_CFG = 8'h30,
   parameter logic [AW-1:0]   OFS_CTL = 8'h34,
   parameter logic [AW-1:0]   OFS_DAT = 8'h38,
   parameter logic [AW-1:0]   OFS_ADR = 8'h3C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 big_endian,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [AW-1:0]        bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 busy,
   input  logic                 done,
   input  logic                 done_rd,
   input  logic [DATA_BITS-1:0] rd_word,
   input  logic                 ta_fail,
   output logic                 start,
   output logic                 start_rd,
   output logic [PHY_BITS-1:0]  start_phy,
   output logic [REGA_BITS-1:0] start_reg,
   output logic [DATA_BITS-1:0] start_data
);
   localparam int NBYTES = 4;
   localparam int RD_BIT = 15;

   logic [31:0] wd_swap, rd_raw, rd_swap, wd, rd_word32;
   logic [PHY_BITS-1:0]  phy_q;
   logic [REGA_BITS-1:0] reg_q;
   logic [DATA_BITS-1:0] dat_q, adr_q;
   logic                 rdcmd_q, enc45_q, rderr_q;
   logic                 wr_cfg, wr_ctl, wr_dat, wr_adr, ctl_start, dat_start;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_swap
         assign wd_swap[8*b +: 8] = bus_wdata[8*(NBYTES-1-b) +: 8];
         assign rd_swap[8*b +: 8] = rd_raw[8*(NBYTES-1-b) +: 8];
      end
   endgenerate

   assign wd        = big_endian ? wd_swap : bus_wdata;
   assign bus_rdata = big_endian ? rd_swap : rd_raw;

   assign wr_cfg = bus_sel & bus_we & (bus_addr == OFS_CFG);
   assign wr_ctl = bus_sel & bus_we & (bus_addr == OFS_CTL);
   assign wr_dat = bus_sel & bus_we & (bus_addr == OFS_DAT);
   assign wr_adr = bus_sel & bus_we & (bus_addr == OFS_ADR);

   assign ctl_start = wr_ctl & ~busy & wd[RD_BIT];
   assign dat_start = wr_dat & ~busy & ~rdcmd_q;

   assign start      = ctl_start | dat_start;
   assign start_rd   = ctl_start;
   assign start_phy  = wr_ctl ? wd[REGA_BITS +: PHY_BITS] : phy_q;
   assign start_reg  = wr_ctl ? wd[REGA_BITS-1:0] : reg_q;
   assign start_data = wd[DATA_BITS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phy_q   <= '0;
         reg_q   <= '0;
         dat_q   <= '0;
         adr_q   <= '0;
         rdcmd_q <= 1'b0;
         enc45_q <= 1'b0;
         rderr_q <= 1'b0;
      end else begin
         if (wr_cfg) enc45_q <= wd[6];
         if (wr_adr) adr_q <= wd[DATA_BITS-1:0];
         if (wr_ctl && !busy) begin
            phy_q   <= wd[REGA_BITS +: PHY_BITS];
            reg_q   <= wd[REGA_BITS-1:0];
            rdcmd_q <= wd[RD_BIT];
         end
         if (wr_dat && !busy) dat_q <= wd[DATA_BITS-1:0];
         if (start) rderr_q <= 1'b0;
         if (done) begin
            rderr_q <= ta_fail;
            if (done_rd) dat_q <= rd_word;
         end
      end
   end

   assign rd_word32 = {{(32-DATA_BITS){1'b0}}, dat_q};

   always_comb begin
      rd_raw = '0;
      if (bus_addr == OFS_CFG) begin
         rd_raw[31] = busy;
         rd_raw[6]  = enc45_q;
         rd_raw[1]  = rderr_q;
      end else if (bus_addr == OFS_CTL) begin
         rd_raw[RD_BIT] = rdcmd_q;
         rd_raw[REGA_BITS +: PHY_BITS] = phy_q;
         rd_raw[REGA_BITS-1:0] = reg_q;
      end else if (bus_addr == OFS_DAT) begin
         rd_raw = rd_word32;
      end else if (bus_addr == OFS_ADR) begin
         rd_raw[DATA_BITS-1:0] = adr_q;
      end
   end

   p_no_start_busy_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
   p_err_clear_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !rderr_q);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_pkg::*;
#(
   parameter int MDC_HALF = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        big_endian,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [7:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic                 rise_stb, fall_stb;
   logic                 start, start_rd, busy, done, done_rd, ta_fail;
   logic [PHY_BITS-1:0]  start_phy;
   logic [REGA_BITS-1:0] start_reg;
   logic [DATA_BITS-1:0] start_data, rd_word;

   mdio_clk_div #(.HALF_PERIOD(MDC_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .mdc(mdc),
      .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_reg_bank #(.AW(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .done_rd(done_rd), .rd_word(rd_word),
      .ta_fail(ta_fail), .start(start), .start_rd(start_rd),
      .start_phy(start_phy), .start_reg(start_reg), .start_data(start_data)
   );

   mdio_frame_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .rise_stb(rise_stb),
      .start(start), .start_rd(start_rd), .start_phy(start_phy),
      .start_reg(start_reg), .start_data(start_data), .mdio_i(mdio_i),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
      .done_rd(done_rd), .rd_word(rd_word), .ta_fail(ta_fail)
   );

   p_busy_after_start_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   p_drive_on_fall_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc));
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
   localparam int HALF = 3;
   localparam logic [7:0] A_CFG = 8'h30, A_CTL = 8'h34, A_DAT = 8'h38, A_ADR = 8'h3C;

   logic clk = 0, rst_n = 0, big_end = 0;
   logic sel = 0, we = 0;
   logic [7:0] addr = 0;
   logic [31:0] wdata = 0, rdata;
   logic mdc, mdio_o, mdio_oe;
   logic mdio_i = 1'b1;

   always #5 clk = ~clk;

   mdio_mgmt_master #(.MDC_HALF(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .big_endian(big_end), .bus_sel(sel), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   int errs = 0, checks = 0;
   logic arm = 0, run = 0;
   int bc = 0;
   logic [63:0] olog, elog;
   logic [15:0] resp = 0;
   logic ta_val = 0;

   // PHY model: logs what the master drives and answers reads
   always @(negedge mdc) begin
      if (arm && !run) begin run = 1; bc = 0; end
      if (run) begin
         #1;
         olog[63-bc] = mdio_o;
         elog[63-bc] = mdio_oe;
         mdio_i = (bc == 47) ? ta_val : ((bc >= 48) ? resp[63-bc] : 1'b1);
      end
   end
   always @(posedge mdc) if (run) begin
      bc++;
      if (bc == 64) begin run = 0; arm = 0; end
   end

   function automatic logic [31:0] bsw(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] v, input bit arm_it);
      @(negedge clk);
      sel = 1; we = 1; addr = a; wdata = big_end ? bsw(v) : v;
      @(posedge clk); #1;
      sel = 0; we = 0;
      if (arm_it) arm = 1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      sel = 1; we = 0; addr = a;
      #2 v = big_end ? bsw(rdata) : rdata;
      @(posedge clk); #1 sel = 0;
   endtask

   task automatic wait_frame();
      while (arm || run) @(negedge clk);
   endtask

   function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
   endfunction

   function automatic logic [63:0] rd_frame(input logic [4:0] p, input logic [4:0] r);
      return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 2'b11, 16'hFFFF};
   endfunction

   task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
      logic [31:0] v;
      wr(A_CTL, {22'd0, p, r}, 0);
      wr(A_DAT, {16'd0, d}, 1);
      wait_frame();
      chk("R2 write frame bits", olog, wr_frame(p, r, d));
      chk("R2 write oe", elog, {64{1'b1}});
      rd(A_CFG, v);
      chk("R4 busy clear after write", {63'd0, v[31]}, 64'd0);
   endtask

   task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d,
                          input logic ta);
      logic [31:0] v;
      logic [63:0] ef;
      resp = d; ta_val = ta;
      wr(A_CTL, {16'd0, 1'b1, 5'd0, p, r}, 1);
      rd(A_CFG, v);
      chk("R4 busy during read", {63'd0, v[31]}, 64'd1);
      chk("R5 err cleared at start", {63'd0, v[1]}, 64'd0);
      wait_frame();
      ef = rd_frame(p, r);
      chk("R3 read frame head", {17'd0, olog[63:17]}, {17'd0, ef[63:17]});
      chk("R3 read oe release", elog, {{47{1'b1}}, 17'd0});
      rd(A_CFG, v);
      chk("R5 read error flag", {63'd0, v[1]}, {63'd0, ta});
      chk("R4 busy clear after read", {63'd0, v[31]}, 64'd0);
      rd(A_DAT, v);
      chk("R3 read data", {32'd0, v}, {48'd0, d});
   endtask

   initial begin
      #(200000 * 10);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      time t0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(A_CFG, v); chk("R1 cfg reset", {32'd0, v}, 64'd0);
      rd(A_CTL, v); chk("R1 ctl reset", {32'd0, v}, 64'd0);
      rd(A_DAT, v); chk("R1 data reset", {32'd0, v}, 64'd0);
      rd(A_ADR, v); chk("R1 addr reset", {32'd0, v}, 64'd0);
      chk("R1 mdio idle", {62'd0, mdio_oe, mdio_o}, 64'd1);

      // R10 MDC period
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      chk("R10 mdc period", 64'($time - t0), 64'(2 * HALF * 10));

      // sweep of write and read frames
      for (int i = 0; i < 4; i++) begin
         logic [4:0] p, r;
         p = 5'(i * 9 + 1);
         r = 5'(31 - i * 7);
         do_write(p, r, 16'(16'hA5C3 ^ (i * 16'h1111)));
         do_read(p ^ 5'h1F, r, 16'(16'h8001 + i * 16'h2345), 1'b0);
      end

      // R5 missing acknowledge, then cleared by next start
      do_read(5'd2, 5'd3, 16'h0F0F, 1'b1);
      wr(A_CTL, {22'd0, 5'd4, 5'd5}, 0);
      wr(A_DAT, 32'h0000_1357, 1);
      rd(A_CFG, v);
      chk("R5 err cleared by next start", {62'd0, v[31], v[1]}, 64'd2);
      wait_frame();
      chk("R2 frame after error", olog, wr_frame(5'd4, 5'd5, 16'h1357));

      // R6 writes while busy ignored
      wr(A_CTL, {22'd0, 5'd3, 5'd4}, 0);
      wr(A_DAT, 32'h0000_1234, 1);
      wr(A_CTL, {16'd0, 1'b1, 5'd0, 5'd9, 5'd9}, 0);
      wr(A_DAT, 32'h0000_BEEF, 0);
      wait_frame();
      chk("R6 frame unchanged", olog, wr_frame(5'd3, 5'd4, 16'h1234));
      rd(A_DAT, v); chk("R6 data kept", {32'd0, v}, 64'h1234);
      rd(A_CTL, v); chk("R6 ctl kept", {32'd0, v}, {54'd0, 5'd3, 5'd4});

      // R6/R3 data write hammered up to the completion edge
      resp = 16'hC3A5; ta_val = 0;
      wr(A_CTL, {16'd0, 1'b1, 5'd0, 5'd7, 5'd8}, 1);
      while (arm || run) begin
         @(negedge clk);
         if (!(arm || run)) break;
         sel = 1; we = 1; addr = A_DAT; wdata = 32'h0000_5A5A;
      end
      sel = 0; we = 0;
      rd(A_DAT, v); chk("R6 completion beats write", {32'd0, v}, 64'hC3A5);
      rd(A_CFG, v); chk("R4 idle after hammer", {62'd0, v[31], v[1]}, 64'd0);

      // R7 data write after read command: stored, no frame
      wr(A_DAT, 32'h0000_4321, 0);
      rd(A_CFG, v); chk("R7 no frame started", {63'd0, v[31]}, 64'd0);
      chk("R7 line idle", {63'd0, mdio_oe}, 64'd0);
      rd(A_DAT, v); chk("R7 data stored", {32'd0, v}, 64'h4321);

      // R9 clause-45 bit and address register storage
      wr(A_CFG, 32'h0000_0040, 0);
      wr(A_ADR, 32'h0000_ABCD, 0);
      rd(A_CFG, v); chk("R9 enc45 stored", {32'd0, v}, 64'h40);
      rd(A_ADR, v); chk("R9 addr stored", {32'd0, v}, 64'hABCD);
      wr(A_CFG, 32'h0, 0);

      // R8 big-endian bus
      big_end = 1;
      do_write(5'd17, 5'd6, 16'h9E37);
      do_read(5'd12, 5'd30, 16'h6B1D, 1'b0);
      @(negedge clk); sel = 1; we = 0; addr = A_DAT;
      #2 chk("R8 raw swapped read", {32'd0, rdata}, {32'd0, 32'h1D6B_0000});
      @(posedge clk); #1 sel = 0;
      big_end = 0;

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule